// File: doc/BRIEF.md
# Interval Timer Host Register Port

This block is the byte-wide register interface that sits between a host bus and three interval-timer channels. The host talks to it through an 8-bit data bus, a 2-bit address and single-cycle read and write strobes. Addresses 0, 1 and 2 are the per-channel data ports. Address 3 is the control port.

A control word either configures one channel or asks for a snapshot of channel state. A configuration sets the byte access order, the counting mode and the decimal/binary select for that channel. A snapshot is either a single-channel count latch or a multi-channel read-back that can freeze counts, status bytes or both. Data-port writes are assembled into a 16-bit reload value according to the channel's access order. When the value is complete, a one-cycle load pulse goes to that channel. Data-port reads return bytes of the live count, a frozen count or a status byte. A frozen count lets the host read both bytes of one count taken at a single instant.

The counting logic of the channels is outside this block. Each channel supplies its current count, its output level and its pending-reload flag.

Top module: `timer_host_port`

## Requirements
- R1: After reset, every reload value is 0x0000, every mode and decimal-select output is 0, no load pulse is active, and the read data register is 0x00. Every channel starts in low-byte-only access.
- R2: A write to address 3 whose bits 7:6 are 0, 1 or 2 and whose bits 5:4 are non-zero configures that channel. Bits 5:4 set the access order: 1 means low byte only, 2 means high byte only, 3 means low then high. Bits 3:1 set the mode and bit 0 sets decimal select. The other channels keep their settings.
- R3: In low-byte-only access, a data write makes the reload value {0x00, byte}. In the cycle after the write, the load pulse of that channel, and only that one, is high for exactly one cycle.
- R4: In high-byte-only access, a data write makes the reload value {byte, 0x00} and pulses the load output once.
- R5: In low-then-high access, the first data write changes neither the reload value nor the load pulse. The second write sets the reload value to {second, first} and pulses the load output once.
- R6: A configuring control word returns that channel's write and read byte pointers to the low byte. A half-finished low/high write sequence is therefore discarded.
- R7: A read of a data port with nothing frozen returns the live count byte that the access order selects. In low-then-high access, consecutive reads alternate low then high. Read data appears in the cycle after the read strobe and holds until the next read. A read of address 3 returns 0x00.
- R8: A control word with bits 7:6 selecting a channel and bits 5:4 equal to 0 freezes that channel's count. Data reads then return the frozen bytes whatever the live count does. After the last byte the access order calls for, reads follow the live count again.
- R9: A count latch or status latch to a channel that already holds a frozen value of that kind is ignored until the held value has been read.
- R10: A control word with bits 7:6 equal to 3 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2, in any combination. Bit 5 low freezes counts and bit 4 low freezes status bytes.
- R11: A frozen status byte holds the output level in bit 7, the pending-reload flag in bit 6, the access order in bits 5:4, the mode in bits 3:1 and decimal select in bit 0. It is returned by the next data read, before any frozen count, and one read releases it.
- R12: A load pulse occurs only in the cycle after a data-port write, and never on more than one channel at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | 0..2 channel data ports, 3 control port |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_rdata | output | 8 | Registered read data |
| ch_mode | output | 9 | Mode per channel, 3 bits each, channel 0 in the low bits |
| ch_bcd | output | 3 | Decimal-select per channel |
| ch_reload | output | 48 | Reload value per channel, 16 bits each |
| ch_load_stb | output | 3 | One-cycle reload-complete pulse per channel |
| ch_count | input | 48 | Current count per channel, 16 bits each |
| ch_out | input | 3 | Output level per channel |
| ch_pending | input | 3 | Pending-reload flag per channel |

## Verification
Directed sequences are run for each access order. Each one writes a byte pattern whose reload value would differ if the byte lanes were swapped or the unused byte were not cleared. Latch and read-back commands are followed by changes to the live counts, so a frozen value can be told apart from a live one. Repeated latches and interleaved status and count snapshots expose any error in hold or read priority. A seeded random mix of configuration, data, latch, read-back and read operations is compared against a bench model. It covers pointer interactions that the directed cases miss, such as reconfiguring a channel between the two halves of a low/high write or read.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } acc_e;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } chan_cfg_t;

endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode #(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [NCH-1:0] cfg_we,
  output logic [NCH-1:0] cnt_latch,
  output logic [NCH-1:0] sts_latch,
  output logic [NCH-1:0] dat_we,
  output logic [NCH-1:0] dat_re
);

  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic       ctl_wr;
  logic [1:0] sel;
  logic [1:0] acc;
  logic       readback;

  assign ctl_wr   = bus_wr && (bus_addr == CTRL_ADDR);
  assign sel      = bus_wdata[7:6];
  assign acc      = bus_wdata[5:4];
  assign readback = (sel == 2'd3);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [1:0] CID = c;
    logic rb_hit;
    assign rb_hit       = ctl_wr && readback && bus_wdata[1+c];
    assign dat_we[c]    = bus_wr && (bus_addr == CID);
    assign dat_re[c]    = bus_rd && (bus_addr == CID);
    assign cfg_we[c]    = ctl_wr && (sel == CID) && (acc != 2'd0);
    assign cnt_latch[c] = (ctl_wr && (sel == CID) && (acc == 2'd0)) ||
                          (rb_hit && !bus_wdata[5]);
    assign sts_latch[c] = rb_hit && !bus_wdata[4];
  end

endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_host_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic           cnt_latch,
  input  logic           sts_latch,
  input  logic           dat_we,
  input  logic           dat_re,
  input  logic [DW-1:0]  wdata,
  input  logic [2*DW-1:0] cur_count,
  input  logic           cur_out,
  input  logic           cur_pend,
  output chan_cfg_t      cfg,
  output logic [2*DW-1:0] reload,
  output logic           load_stb,
  output logic [DW-1:0]  rd_byte
);

  localparam int CW = 2 * DW;

  chan_cfg_t      cfg_q;
  logic [CW-1:0]  reload_q;
  logic           stb_q;
  logic           wptr;
  logic [DW-1:0]  lo_stage;
  logic           rptr;
  logic           cheld;
  logic [CW-1:0]  cval;
  logic           sheld;
  logic [DW-1:0]  sval;
  logic [CW-1:0]  src;

  assign cfg      = cfg_q;
  assign reload   = reload_q;
  assign load_stb = stb_q;

  // byte offered to the next read, from the state before that read
  always_comb begin
    src = cheld ? cval : cur_count;
    if (sheld) begin
      rd_byte = sval;
    end else begin
      case (cfg_q.acc)
        ACC_LO:  rd_byte = src[DW-1:0];
        ACC_HI:  rd_byte = src[CW-1:DW];
        default: rd_byte = rptr ? src[CW-1:DW] : src[DW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '{acc: ACC_LO, mode: 3'd0, bcd: 1'b0};
      reload_q <= '0;
      stb_q    <= 1'b0;
      wptr     <= 1'b0;
      lo_stage <= '0;
      rptr     <= 1'b0;
      cheld    <= 1'b0;
      cval     <= '0;
      sheld    <= 1'b0;
      sval     <= '0;
    end else begin
      stb_q <= 1'b0;

      if (cfg_we) begin
        cfg_q <= '{acc: acc_e'(wdata[5:4]), mode: wdata[3:1], bcd: wdata[0]};
        wptr  <= 1'b0;
        rptr  <= 1'b0;
      end else if (dat_we) begin
        case (cfg_q.acc)
          ACC_LO: begin
            reload_q <= {{DW{1'b0}}, wdata};
            stb_q    <= 1'b1;
          end
          ACC_HI: begin
            reload_q <= {wdata, {DW{1'b0}}};
            stb_q    <= 1'b1;
          end
          default: begin
            if (!wptr) begin
              lo_stage <= wdata;
              wptr     <= 1'b1;
            end else begin
              reload_q <= {wdata, lo_stage};
              stb_q    <= 1'b1;
              wptr     <= 1'b0;
            end
          end
        endcase
      end

      if (cnt_latch && !cheld) begin
        cheld <= 1'b1;
        cval  <= cur_count;
      end
      if (sts_latch && !sheld) begin
        sheld <= 1'b1;
        sval  <= {cur_out, cur_pend, cfg_q};
      end

      if (dat_re) begin
        if (sheld) begin
          sheld <= 1'b0;
        end else begin
          if (cfg_q.acc == ACC_LOHI) rptr <= ~rptr;
          if (cheld && (cfg_q.acc != ACC_LOHI || rptr)) cheld <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/timer_host_port.sv
module timer_host_port
  import tmr_host_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_wr,
  input  logic            bus_rd,
  output logic [DW-1:0]   bus_rdata,
  output logic [8:0]      ch_mode,
  output logic [2:0]      ch_bcd,
  output logic [6*DW-1:0] ch_reload,
  output logic [2:0]      ch_load_stb,
  input  logic [6*DW-1:0] ch_count,
  input  logic [2:0]      ch_out,
  input  logic [2:0]      ch_pending
);

  localparam int NCH = 3;
  localparam int CW  = 2 * DW;

  logic [NCH-1:0] cfg_we, cnt_latch, sts_latch, dat_we, dat_re;
  logic [DW-1:0]  rd_byte [NCH];

  tmr_cmd_decode #(.NCH(NCH), .DW(DW)) u_dec (
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cfg_we    (cfg_we),
    .cnt_latch (cnt_latch),
    .sts_latch (sts_latch),
    .dat_we    (dat_we),
    .dat_re    (dat_re)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    chan_cfg_t cfg;
    tmr_chan_port #(.DW(DW)) u_port (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (cfg_we[c]),
      .cnt_latch (cnt_latch[c]),
      .sts_latch (sts_latch[c]),
      .dat_we    (dat_we[c]),
      .dat_re    (dat_re[c]),
      .wdata     (bus_wdata),
      .cur_count (ch_count[c*CW +: CW]),
      .cur_out   (ch_out[c]),
      .cur_pend  (ch_pending[c]),
      .cfg       (cfg),
      .reload    (ch_reload[c*CW +: CW]),
      .load_stb  (ch_load_stb[c]),
      .rd_byte   (rd_byte[c])
    );
    assign ch_mode[c*3 +: 3] = cfg.mode;
    assign ch_bcd[c]         = cfg.bcd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        2'd0:    bus_rdata <= rd_byte[0];
        2'd1:    bus_rdata <= rd_byte[1];
        2'd2:    bus_rdata <= rd_byte[2];
        default: bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/tmr_host_chk.sv
module tmr_host_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      bus_addr,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [DW-1:0]   bus_rdata,
  input logic [8:0]      ch_mode,
  input logic [2:0]      ch_bcd,
  input logic [6*DW-1:0] ch_reload,
  input logic [2:0]      ch_load_stb
);

  p_stb_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_load_stb));

  p_stb_after_data_wr_r12: assert property (@(posedge clk) disable iff (rst)
    (ch_load_stb != 3'd0) |-> ($past(bus_wr) && $past(bus_addr) != 2'd3));

  p_reload_with_stb_r3: assert property (@(posedge clk) disable iff (rst)
    (ch_reload != $past(ch_reload)) |-> (ch_load_stb != 3'd0));

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !($past(bus_wr) && $past(bus_addr) == 2'd3) |-> ($stable(ch_mode) && $stable(ch_bcd)));

  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata));

endmodule

bind timer_host_port tmr_host_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .ch_mode     (ch_mode),
  .ch_bcd      (ch_bcd),
  .ch_reload   (ch_reload),
  .ch_load_stb (ch_load_stb)
);

// File: tb/timer_host_port_test.sv
module timer_host_port_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;
  logic [47:0] ch_reload;
  logic [2:0]  ch_load_stb;
  logic [47:0] ch_count;
  logic [2:0]  ch_out;
  logic [2:0]  ch_pending;

  logic [15:0] cnt [3];
  logic        outb [3];
  logic        pend [3];

  assign ch_count   = {cnt[2], cnt[1], cnt[0]};
  assign ch_out     = {outb[2], outb[1], outb[0]};
  assign ch_pending = {pend[2], pend[1], pend[0]};

  always #4 clk = ~clk;

  timer_host_port uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ch_reload(ch_reload),
    .ch_load_stb(ch_load_stb), .ch_count(ch_count), .ch_out(ch_out),
    .ch_pending(ch_pending)
  );

  int total = 0;
  int bad   = 0;

  // bench model of the register port
  logic [1:0]  m_acc [3];
  logic [2:0]  m_mode [3];
  logic        m_bcd [3];
  logic [15:0] m_rel [3];
  logic        m_wptr [3], m_rptr [3], m_ch [3], m_sh [3];
  logic [7:0]  m_lo [3], m_sv [3];
  logic [15:0] m_cv [3];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [7:0] exp_rd(input int c);
    logic [15:0] s;
    if (m_sh[c]) return m_sv[c];
    s = m_ch[c] ? m_cv[c] : cnt[c];
    case (m_acc[c])
      2'd1:    return s[7:0];
      2'd2:    return s[15:8];
      default: return m_rptr[c] ? s[15:8] : s[7:0];
    endcase
  endfunction

  task automatic model_rd(input int c);
    if (m_sh[c]) m_sh[c] = 1'b0;
    else begin
      if (m_ch[c] && (m_acc[c] != 2'd3 || m_rptr[c])) m_ch[c] = 1'b0;
      if (m_acc[c] == 2'd3) m_rptr[c] = ~m_rptr[c];
    end
  endtask

  task automatic model_ctrl(input logic [7:0] d);
    int c;
    if (d[7:6] == 2'd3) begin
      for (int k = 0; k < 3; k++) if (d[1+k]) begin
        if (!d[5] && !m_ch[k]) begin m_ch[k] = 1'b1; m_cv[k] = cnt[k]; end
        if (!d[4] && !m_sh[k]) begin
          m_sh[k] = 1'b1;
          m_sv[k] = {outb[k], pend[k], m_acc[k], m_mode[k], m_bcd[k]};
        end
      end
    end else begin
      c = int'(d[7:6]);
      if (d[5:4] == 2'd0) begin
        if (!m_ch[c]) begin m_ch[c] = 1'b1; m_cv[c] = cnt[c]; end
      end else begin
        m_acc[c] = d[5:4]; m_mode[c] = d[3:1]; m_bcd[c] = d[0];
        m_wptr[c] = 1'b0; m_rptr[c] = 1'b0;
      end
    end
  endtask

  function automatic logic [8:0] exp_mode();
    return {m_mode[2], m_mode[1], m_mode[0]};
  endfunction

  function automatic logic [47:0] exp_reload();
    return {m_rel[2], m_rel[1], m_rel[0]};
  endfunction

  task automatic pulse(input logic [1:0] a, input logic [7:0] d, input bit rd);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = !rd; bus_rd = rd;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic ctrl(input logic [7:0] d, input string tag);
    pulse(2'd3, d, 1'b0);
    model_ctrl(d);
    check(ch_mode == exp_mode() && ch_bcd == {m_bcd[2], m_bcd[1], m_bcd[0]},
          tag, {20'd0, ch_bcd, ch_mode}, {20'd0, m_bcd[2], m_bcd[1], m_bcd[0], exp_mode()});
  endtask

  task automatic dwrite(input int c, input logic [7:0] d, input string tag);
    logic [2:0] es = 3'd0;
    pulse(2'(c), d, 1'b0);
    case (m_acc[c])
      2'd1: begin m_rel[c] = {8'h00, d}; es[c] = 1'b1; end
      2'd2: begin m_rel[c] = {d, 8'h00}; es[c] = 1'b1; end
      default: begin
        if (!m_wptr[c]) begin m_lo[c] = d; m_wptr[c] = 1'b1; end
        else begin m_rel[c] = {d, m_lo[c]}; m_wptr[c] = 1'b0; es[c] = 1'b1; end
      end
    endcase
    check(ch_reload == exp_reload(), tag, ch_reload[31:0], exp_reload()[31:0]);
    check(ch_load_stb == es, tag, {29'd0, ch_load_stb}, {29'd0, es});
    @(negedge clk);
    check(ch_load_stb == 3'd0, tag, {29'd0, ch_load_stb}, 32'd0);
  endtask

  task automatic dread(input int c, input string tag);
    logic [7:0] e;
    e = (c == 3) ? 8'h00 : exp_rd(c);
    pulse(2'(c), 8'h00, 1'b1);
    if (c != 3) model_rd(c);
    check(bus_rdata == e, tag, {24'd0, bus_rdata}, {24'd0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3; k++) begin
      cnt[k] = 16'h0; outb[k] = 1'b0; pend[k] = 1'b0;
      m_acc[k] = 2'd1; m_mode[k] = 3'd0; m_bcd[k] = 1'b0; m_rel[k] = 16'h0;
      m_wptr[k] = 1'b0; m_rptr[k] = 1'b0; m_ch[k] = 1'b0; m_sh[k] = 1'b0;
      m_lo[k] = 8'h0; m_sv[k] = 8'h0; m_cv[k] = 16'h0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(ch_reload == 48'd0 && ch_load_stb == 3'd0 && ch_mode == 9'd0 &&
          ch_bcd == 3'd0 && bus_rdata == 8'd0, "R1 reset",
          ch_reload[31:0], 32'd0);

    // R2 configure channel 0: low only, mode 2, decimal
    ctrl(8'b00_01_010_1, "R2 config ch0");
    check(ch_mode == 9'b000_000_010 && ch_bcd == 3'b001, "R2 literal",
          {23'd0, ch_mode}, 32'h2);
    // R3 low-only write
    dwrite(0, 8'hA5, "R3 low only");
    check(ch_reload[15:0] == 16'h00A5, "R3 literal", {16'd0, ch_reload[15:0]}, 32'hA5);
    // R4 high-only write
    ctrl(8'b01_10_011_0, "R2 config ch1");
    dwrite(1, 8'h3C, "R4 high only");
    check(ch_reload[31:16] == 16'h3C00, "R4 literal", {16'd0, ch_reload[31:16]}, 32'h3C00);
    // R5 low then high
    ctrl(8'b10_11_100_0, "R2 config ch2");
    dwrite(2, 8'h34, "R5 first byte");
    dwrite(2, 8'h12, "R5 second byte");
    check(ch_reload[47:32] == 16'h1234, "R5 literal", {16'd0, ch_reload[47:32]}, 32'h1234);
    // R6 control word restarts the byte pointer
    dwrite(2, 8'h77, "R6 half write");
    ctrl(8'b10_11_100_0, "R6 reconfig");
    dwrite(2, 8'h11, "R6 low");
    dwrite(2, 8'h22, "R6 high");
    check(ch_reload[47:32] == 16'h2211, "R6 literal", {16'd0, ch_reload[47:32]}, 32'h2211);
    // R7 live reads
    cnt[2] = 16'hBEEF; cnt[0] = 16'h1234;
    dread(2, "R7 live low");
    dread(2, "R7 live high");
    dread(0, "R7 low only");
    dread(3, "R7 control port");
    // R8 count latch freezes
    cnt[2] = 16'hCAFE;
    ctrl(8'b10_00_0000, "R8 latch");
    cnt[2] = 16'h0001;
    dread(2, "R8 frozen low");
    check(bus_rdata == 8'hFE, "R8 literal", {24'd0, bus_rdata}, 32'hFE);
    dread(2, "R8 frozen high");
    dread(2, "R8 live again low");
    dread(2, "R8 live again high");
    // R9 repeated latch ignored
    cnt[2] = 16'h1111;
    ctrl(8'b10_00_0000, "R9 latch one");
    cnt[2] = 16'h2222;
    ctrl(8'b10_00_0000, "R9 latch two");
    dread(2, "R9 held low");
    dread(2, "R9 held high");
    // R10 R11 read-back of count and status on channels 0 and 1
    outb[0] = 1'b1; pend[0] = 1'b1; outb[1] = 1'b0; pend[1] = 1'b1;
    cnt[0] = 16'h0A0B; cnt[1] = 16'h0C0D;
    ctrl(8'b11_0_0_011_0, "R10 readback");
    cnt[0] = 16'h5555; cnt[1] = 16'h6666;
    dread(0, "R11 status ch0");
    check(bus_rdata == 8'hD5, "R11 literal", {24'd0, bus_rdata}, 32'hD5);
    dread(0, "R10 count ch0");
    dread(1, "R11 status ch1");
    dread(1, "R10 count ch1");
    dread(1, "R10 live ch1");
    // R9 status latch ignored while held
    ctrl(8'b11_1_0_001_0, "R9 status one");
    outb[0] = 1'b0;
    ctrl(8'b11_1_0_001_0, "R9 status two");
    dread(0, "R9 status held");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = int'($urandom % 6);
      int c  = int'($urandom % 3);
      case (op)
        0: ctrl({2'(c), 2'(($urandom % 3) + 1), 4'($urandom)}, "R2 random config");
        1: dwrite(c, 8'($urandom), "R5 random write");
        2, 3: dread(int'($urandom % 4), "R7 random read");
        4: ctrl({2'(c), 6'b00_0000}, "R8 random latch");
        default: ctrl({2'b11, 2'($urandom), 3'($urandom), 1'b0}, "R10 random readback");
      endcase
      cnt[c]  = 16'($urandom);
      outb[c] = 1'($urandom);
      pend[c] = 1'($urandom);
    end

    summary();
  end

endmodule